// File: doc/BRIEF.md
# Oversampling Scan Acquisition Sequencer

This block steps through a small programmable list of acquisition entries. Each entry names a channel, a gain code and whether the channel is analog or digital. For an analog entry the sequencer places the channel and gain on a select interface and keeps them unchanged. It then fires a burst of conversion starts at the converter, adds up the returned 16-bit samples and emits their average as one 16-bit word. A digital entry is read once and its value goes out unchanged. Each output word carries the index of the entry it came from. Words leave on a valid/ready stream.

The oversampling factor is a power of two, given as its base-2 logarithm. In free-running pacing, each conversion starts as soon as the previous sample has come back. In line-cycle pacing, the gap between starts is a fixed clock count: the mains period (50 Hz or 60 Hz, chosen by a configuration bit) divided by the burst length and rounded down. A burst therefore spans one mains period. An error flag warns when that gap is shorter than the converter's minimum conversion time. The list is walked once, ending with a done pulse, or repeated for as long as the continuous bit is set.

Top module: `oversample_scan_seq`

## Requirements
- R1: Entries are processed in ascending index order from 0 to `listLast`. Each output word carries its entry index on `outIdx`.
- R2: With `osEnable`=1, an analog entry issues exactly 2^k conversion starts. Its output is floor(sum of the 2^k samples / 2^k), where k is the effective log2 factor.
- R3: A digital entry (`listWrDigital`=1) issues exactly one conversion start, and the returned sample is output unchanged, whatever the oversampling settings.
- R4: With `osEnable`=0, an analog entry issues exactly one conversion start, and its sample is output unchanged.
- R5: From an entry's first conversion start to its last, `selChan`, `selGain` and `selDigital` do not change, and they equal that entry's programmed fields.
- R6: In free pacing (`lineMode`=0), each conversion start after the first in a burst is asserted in the cycle right after the previous sample's `adcValid` cycle.
- R7: In line pacing (`lineMode`=1), consecutive starts within a burst are exactly floor(P / 2^k) cycles apart. P is `LINE60_CLKS` when `line60`=1 and `LINE50_CLKS` when `line60`=0.
- R8: `paceErr` is captured at `start` and equals 1 exactly when `lineMode`=1 and the line-pacing interval is below `MIN_CONV_CLKS`. It holds that value until the next start.
- R9: While `outValid`=1, no conversion start is issued, and a stalled output word keeps its data and index. No word is lost under backpressure.
- R10: In single-scan mode (`continuous`=0 when the last entry finishes), `done` pulses for exactly one cycle, in the same cycle in which the last word becomes valid. `busy` is 0 in that cycle.
- R11: With `continuous`=1 when the last entry finishes, the walk wraps to entry 0 with no done pulse.
- R12: The effective log2 factor k is `osLog2` clamped to 1..14: a value of 0 acts as 1, and 15 acts as 14.
- R13: After reset, and after a reset applied in the middle of a scan, `busy`, `outValid`, `convStart`, `done` and `paceErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| listWrEn | input | 1 | Write strobe for one list entry |
| listWrIdx | input | IDX_W | Entry index written |
| listWrChan | input | CHAN_W | Channel number of the entry |
| listWrGain | input | GAIN_W | Gain code of the entry |
| listWrDigital | input | 1 | 1 marks a digital entry |
| listLast | input | IDX_W | Index of the last entry in the scan |
| osEnable | input | 1 | Enables oversampling of analog entries |
| osLog2 | input | 4 | log2 of the oversampling factor |
| lineMode | input | 1 | Selects line-cycle pacing |
| line60 | input | 1 | 1 selects a 60 Hz period, 0 a 50 Hz period |
| continuous | input | 1 | Repeat the scan after the last entry |
| start | input | 1 | Start pulse, taken while idle |
| selChan | output | CHAN_W | Selected channel |
| selGain | output | GAIN_W | Selected gain code |
| selDigital | output | 1 | Selected entry is digital |
| convStart | output | 1 | One-cycle conversion start |
| adcValid | input | 1 | Sample return strobe |
| adcData | input | SAMPLE_W | Returned sample |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | SAMPLE_W | Averaged or passed-through value |
| outIdx | output | IDX_W | Entry index of the word |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | Single-scan completion pulse |
| paceErr | output | 1 | Line-pacing interval too short |

## Verification
The hardest case to reach from the ports is backpressure landing exactly at an entry boundary. The word for one entry is held unconsumed, and the sequencer must then keep the next entry's burst from starting, without losing any sample already taken. The bench holds `outReady` low from the start of a two-entry scan with an 8-sample burst. It checks that exactly eight conversions have happened and that the first word waits with index 0. It then releases the stream and checks both averages against its own sample model. Line pacing is checked by timing every start gap inside each burst, including a setting whose interval is shorter than the converter latency.

// File: rtl/oss_pkg.sv
package oss_pkg;

  localparam int MAX_LOG2 = 14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAITOUT,
    ST_RUN,
    ST_EMIT
  } seq_state_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic       accClr;
    logic       accAdd;
    logic       outLoad;
    logic [3:0] outShift;
  } oss_strobe_t;

  function automatic logic [3:0] clampLog2(input logic [3:0] v);
    if (v == 4'd0)
      return 4'd1;
    else if (v > 4'(MAX_LOG2))
      return 4'(MAX_LOG2);
    else
      return v;
  endfunction

endpackage

// File: rtl/oss_ctrl.sv
module oss_ctrl
  import oss_pkg::*;
#(
  parameter int LIST_DEPTH    = 8,
  parameter int CHAN_W        = 5,
  parameter int GAIN_W        = 3,
  parameter int LINE50_CLKS   = 2000000,
  parameter int LINE60_CLKS   = 1666667,
  parameter int MIN_CONV_CLKS = 50,
  localparam int IDX_W        = $clog2(LIST_DEPTH),
  localparam int PMAX         = (LINE50_CLKS > LINE60_CLKS) ? LINE50_CLKS : LINE60_CLKS,
  localparam int TIMER_W      = $clog2(PMAX + 1),
  localparam int CNT_W        = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              listWrEn,
  input  logic [IDX_W-1:0]  listWrIdx,
  input  logic [CHAN_W-1:0] listWrChan,
  input  logic [GAIN_W-1:0] listWrGain,
  input  logic              listWrDigital,
  input  logic [IDX_W-1:0]  listLast,
  input  logic              osEnable,
  input  logic [3:0]        osLog2,
  input  logic              lineMode,
  input  logic              line60,
  input  logic              continuous,
  input  logic              start,
  input  logic              outFree,
  input  logic              adcValid,
  output logic [CHAN_W-1:0] selChan,
  output logic [GAIN_W-1:0] selGain,
  output logic              selDigital,
  output logic              convStart,
  output logic              busy,
  output logic              done,
  output logic              paceErr,
  output logic [IDX_W-1:0]  entryIdx,
  output oss_strobe_t       strb
);

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [GAIN_W-1:0] gain;
    logic              digital;
  } entry_t;

  localparam logic [TIMER_W-1:0] P50   = TIMER_W'(LINE50_CLKS);
  localparam logic [TIMER_W-1:0] P60   = TIMER_W'(LINE60_CLKS);
  localparam logic [TIMER_W-1:0] MIN_T = TIMER_W'(MIN_CONV_CLKS);

  entry_t listMem [LIST_DEPTH];

  // one register per list slot
  for (genvar gi = 0; gi < LIST_DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        listMem[gi] <= '0;
      else if (listWrEn && (listWrIdx == IDX_W'(gi)))
        listMem[gi] <= '{chan: listWrChan, gain: listWrGain, digital: listWrDigital};
    end
  end

  seq_state_e        state;
  logic [IDX_W-1:0]  entryIdxQ;
  logic [3:0]        kQ;
  logic              lineQ;
  logic [TIMER_W-1:0] intervalQ;
  logic [TIMER_W-1:0] paceCnt;
  logic              paceErrQ;
  logic              doneQ;
  logic [CNT_W-1:0]  issued;
  logic [CNT_W-1:0]  got;
  logic [CNT_W-1:0]  burstQ;
  logic [3:0]        shiftQ;
  entry_t            selQ;

  // values captured at start
  logic [3:0]         kNext;
  logic [TIMER_W-1:0] periodSel;
  logic [TIMER_W-1:0] intervalNext;
  logic [TIMER_W-1:0] paceReload;
  entry_t             curEntry;
  logic               sampleTake;

  always_comb begin
    kNext        = osEnable ? clampLog2(osLog2) : 4'd0;
    periodSel    = line60 ? P60 : P50;
    intervalNext = periodSel >> kNext;
    paceReload   = (intervalQ == '0) ? '0 : intervalQ - 1'b1;
    curEntry     = listMem[entryIdxQ];
    sampleTake   = (state == ST_RUN) && adcValid && (got != burstQ);
    convStart    = (state == ST_RUN) && (issued != burstQ) &&
                   (lineQ ? (paceCnt == '0) : (got == issued));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      entryIdxQ <= '0;
      kQ        <= '0;
      lineQ     <= 1'b0;
      intervalQ <= '0;
      paceCnt   <= '0;
      paceErrQ  <= 1'b0;
      doneQ     <= 1'b0;
      issued    <= '0;
      got       <= '0;
      burstQ    <= '0;
      shiftQ    <= '0;
      selQ      <= '0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            kQ        <= kNext;
            lineQ     <= lineMode;
            intervalQ <= intervalNext;
            paceErrQ  <= lineMode && (intervalNext < MIN_T);
            entryIdxQ <= '0;
            state     <= ST_WAITOUT;
          end
        end
        ST_WAITOUT: begin
          // the next burst waits until the previous word has left
          if (outFree) begin
            selQ    <= curEntry;
            burstQ  <= curEntry.digital ? CNT_W'(1) : (CNT_W'(1) << kQ);
            shiftQ  <= curEntry.digital ? 4'd0 : kQ;
            issued  <= '0;
            got     <= '0;
            paceCnt <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (convStart)
            issued <= issued + 1'b1;
          if (lineQ) begin
            if (convStart)
              paceCnt <= paceReload;
            else if (paceCnt != '0)
              paceCnt <= paceCnt - 1'b1;
          end
          if (sampleTake)
            got <= got + 1'b1;
          if (got == burstQ)
            state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (entryIdxQ == listLast) begin
            entryIdxQ <= '0;
            if (continuous) begin
              state <= ST_WAITOUT;
            end else begin
              doneQ <= 1'b1;
              state <= ST_IDLE;
            end
          end else begin
            entryIdxQ <= entryIdxQ + 1'b1;
            state     <= ST_WAITOUT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.accClr   = (state == ST_WAITOUT) && outFree;
    strb.accAdd   = sampleTake;
    strb.outLoad  = (state == ST_EMIT);
    strb.outShift = shiftQ;
  end

  assign selChan    = selQ.chan;
  assign selGain    = selQ.gain;
  assign selDigital = selQ.digital;
  assign busy       = (state != ST_IDLE);
  assign done       = doneQ;
  assign paceErr    = paceErrQ;
  assign entryIdx   = entryIdxQ;

endmodule

// File: rtl/oss_dpath.sv
module oss_dpath
  import oss_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 3,
  localparam int ACC_W   = SAMPLE_W + MAX_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  input  oss_strobe_t         strb,
  input  logic [SAMPLE_W-1:0] adcData,
  input  logic [IDX_W-1:0]    entryIdx,
  input  logic                outReady,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outData,
  output logic [IDX_W-1:0]    outIdx,
  output logic                outFree
);

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (strb.accClr)
      acc <= '0;
    else if (strb.accAdd)
      acc <= acc + ACC_W'(adcData);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      outIdx   <= '0;
    end else if (strb.outLoad) begin
      outValid <= 1'b1;
      outData  <= SAMPLE_W'(acc >> strb.outShift);
      outIdx   <= entryIdx;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  assign outFree = !outValid;

endmodule

// File: rtl/oversample_scan_seq.sv
module oversample_scan_seq
  import oss_pkg::*;
#(
  parameter int LIST_DEPTH    = 8,
  parameter int CHAN_W        = 5,
  parameter int GAIN_W        = 3,
  parameter int SAMPLE_W      = 16,
  parameter int LINE50_CLKS   = 2000000,
  parameter int LINE60_CLKS   = 1666667,
  parameter int MIN_CONV_CLKS = 50,
  localparam int IDX_W        = $clog2(LIST_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                listWrEn,
  input  logic [IDX_W-1:0]    listWrIdx,
  input  logic [CHAN_W-1:0]   listWrChan,
  input  logic [GAIN_W-1:0]   listWrGain,
  input  logic                listWrDigital,
  input  logic [IDX_W-1:0]    listLast,
  input  logic                osEnable,
  input  logic [3:0]          osLog2,
  input  logic                lineMode,
  input  logic                line60,
  input  logic                continuous,
  input  logic                start,
  output logic [CHAN_W-1:0]   selChan,
  output logic [GAIN_W-1:0]   selGain,
  output logic                selDigital,
  output logic                convStart,
  input  logic                adcValid,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic                outValid,
  input  logic                outReady,
  output logic [SAMPLE_W-1:0] outData,
  output logic [IDX_W-1:0]    outIdx,
  output logic                busy,
  output logic                done,
  output logic                paceErr
);

  oss_strobe_t      strb;
  logic [IDX_W-1:0] entryIdx;
  logic             outFree;

  oss_ctrl #(
    .LIST_DEPTH   (LIST_DEPTH),
    .CHAN_W       (CHAN_W),
    .GAIN_W       (GAIN_W),
    .LINE50_CLKS  (LINE50_CLKS),
    .LINE60_CLKS  (LINE60_CLKS),
    .MIN_CONV_CLKS(MIN_CONV_CLKS)
  ) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .listWrEn     (listWrEn),
    .listWrIdx    (listWrIdx),
    .listWrChan   (listWrChan),
    .listWrGain   (listWrGain),
    .listWrDigital(listWrDigital),
    .listLast     (listLast),
    .osEnable     (osEnable),
    .osLog2       (osLog2),
    .lineMode     (lineMode),
    .line60       (line60),
    .continuous   (continuous),
    .start        (start),
    .outFree      (outFree),
    .adcValid     (adcValid),
    .selChan      (selChan),
    .selGain      (selGain),
    .selDigital   (selDigital),
    .convStart    (convStart),
    .busy         (busy),
    .done         (done),
    .paceErr      (paceErr),
    .entryIdx     (entryIdx),
    .strb         (strb)
  );

  oss_dpath #(
    .SAMPLE_W(SAMPLE_W),
    .IDX_W   (IDX_W)
  ) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .adcData (adcData),
    .entryIdx(entryIdx),
    .outReady(outReady),
    .outValid(outValid),
    .outData (outData),
    .outIdx  (outIdx),
    .outFree (outFree)
  );

endmodule

// File: rtl/oss_chk.sv
module oss_chk #(
  parameter int CHAN_W   = 5,
  parameter int GAIN_W   = 3,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [CHAN_W-1:0]   selChan,
  input logic [GAIN_W-1:0]   selGain,
  input logic                selDigital,
  input logic                convStart,
  input logic                outValid,
  input logic                outReady,
  input logic [SAMPLE_W-1:0] outData,
  input logic [IDX_W-1:0]    outIdx,
  input logic                busy,
  input logic                done,
  input logic                paceErr
);

  logic              haveRef;
  logic              loadSeen;
  logic              prevValid;
  logic [CHAN_W-1:0] refChan;
  logic [GAIN_W-1:0] refGain;
  logic              refDig;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveRef   <= 1'b0;
      loadSeen  <= 1'b0;
      prevValid <= 1'b0;
      refChan   <= '0;
      refGain   <= '0;
      refDig    <= 1'b0;
    end else begin
      prevValid <= outValid;
      if (convStart) begin
        haveRef  <= 1'b1;
        loadSeen <= 1'b0;
        refChan  <= selChan;
        refGain  <= selGain;
        refDig   <= selDigital;
      end else if (outValid && !prevValid) begin
        loadSeen <= 1'b1;
      end
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (convStart && haveRef && !loadSeen) |->
      (selChan == refChan && selGain == refGain && selDigital == refDig));

  // R9
  stall_noconv_chk: assert property (@(posedge clk) disable iff (rst)
    convStart |-> !outValid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outIdx)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && outValid));

  // R13
  conv_busy_chk: assert property (@(posedge clk) disable iff (rst)
    convStart |-> busy);

  // R8
  pace_err_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(paceErr));

endmodule

bind oversample_scan_seq oss_chk #(
  .CHAN_W  (CHAN_W),
  .GAIN_W  (GAIN_W),
  .SAMPLE_W(SAMPLE_W),
  .IDX_W   (IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .selChan   (selChan),
  .selGain   (selGain),
  .selDigital(selDigital),
  .convStart (convStart),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .outIdx    (outIdx),
  .busy      (busy),
  .done      (done),
  .paceErr   (paceErr)
);

// File: tb/oversample_scan_seq_tb_top.sv
module oversample_scan_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIST_DEPTH = 8;
  localparam int IDX_W      = 3;
  localparam int CHAN_W     = 5;
  localparam int GAIN_W     = 3;
  localparam int SAMPLE_W   = 16;
  localparam int L50        = 8192;
  localparam int L60        = 6826;
  localparam int MINC       = 4;
  localparam int ADC_LAT    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic listWrEn = 1'b0;
  logic [IDX_W-1:0] listWrIdx = '0;
  logic [CHAN_W-1:0] listWrChan = '0;
  logic [GAIN_W-1:0] listWrGain = '0;
  logic listWrDigital = 1'b0;
  logic [IDX_W-1:0] listLast = '0;
  logic osEnable = 1'b0;
  logic [3:0] osLog2 = '0;
  logic lineMode = 1'b0;
  logic line60 = 1'b0;
  logic continuous = 1'b0;
  logic start = 1'b0;
  logic outReady = 1'b1;
  logic [CHAN_W-1:0] selChan;
  logic [GAIN_W-1:0] selGain;
  logic selDigital, convStart, adcValid, outValid, busy, done, paceErr;
  logic [SAMPLE_W-1:0] adcData, outData;
  logic [IDX_W-1:0] outIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  oversample_scan_seq #(
    .LIST_DEPTH(LIST_DEPTH), .CHAN_W(CHAN_W), .GAIN_W(GAIN_W), .SAMPLE_W(SAMPLE_W),
    .LINE50_CLKS(L50), .LINE60_CLKS(L60), .MIN_CONV_CLKS(MINC)
  ) dut_i (
    .clk(clk), .rst(rst), .listWrEn(listWrEn), .listWrIdx(listWrIdx),
    .listWrChan(listWrChan), .listWrGain(listWrGain), .listWrDigital(listWrDigital),
    .listLast(listLast), .osEnable(osEnable), .osLog2(osLog2), .lineMode(lineMode),
    .line60(line60), .continuous(continuous), .start(start), .selChan(selChan),
    .selGain(selGain), .selDigital(selDigital), .convStart(convStart),
    .adcValid(adcValid), .adcData(adcData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outIdx(outIdx), .busy(busy), .done(done), .paceErr(paceErr)
  );

  // ---------------- converter model ----------------
  function automatic logic [15:0] fval(input int unsigned g);
    int unsigned t;
    t = g * 32'd40503 + 32'd12345;
    return t[15:0];
  endfunction

  int unsigned gn = 0;
  logic [15:0] pv [ADC_LAT];
  logic        pk [ADC_LAT];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ADC_LAT; i++) pk[i] <= 1'b0;
    end else begin
      pk[0] <= convStart;
      pv[0] <= fval(gn);
      if (convStart) gn <= gn + 1;
      for (int i = 1; i < ADC_LAT; i++) begin
        pk[i] <= pk[i-1];
        pv[i] <= pv[i-1];
      end
    end
  end
  assign adcValid = pk[ADC_LAT-1];
  assign adcData  = pv[ADC_LAT-1];

  // ---------------- monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int recCnt, doneCnt, convCnt, lastConv, minGap, maxGap, selChange, loadCnt;
  bit haveLast, gapSeen, loadSince, prevOV;
  logic [IDX_W-1:0]    recIdx  [64];
  logic [SAMPLE_W-1:0] recData [64];
  logic [CHAN_W-1:0]   loadChan [64];
  logic [CHAN_W-1:0]   lastChan;
  logic [GAIN_W-1:0]   lastGain;

  always @(negedge clk) begin
    if (outValid && outReady) begin
      if (recCnt < 64) begin
        recIdx[recCnt]  = outIdx;
        recData[recCnt] = outData;
      end
      recCnt++;
    end
    if (done) doneCnt++;
    if (outValid && !prevOV) begin
      loadSince = 1;
      if (loadCnt < 64) loadChan[loadCnt] = lastChan;
      loadCnt++;
    end
    prevOV = outValid;
    if (convStart) begin
      convCnt++;
      if (haveLast && !loadSince) begin
        if (cyc - lastConv < minGap) minGap = cyc - lastConv;
        if (cyc - lastConv > maxGap) maxGap = cyc - lastConv;
        gapSeen = 1;
        if (selChan != lastChan || selGain != lastGain) selChange++;
      end
      lastConv  = cyc;
      lastChan  = selChan;
      lastGain  = selGain;
      haveLast  = 1;
      loadSince = 0;
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clrStats();
    recCnt = 0; doneCnt = 0; convCnt = 0; haveLast = 0; gapSeen = 0;
    minGap = 1 << 30; maxGap = 0; selChange = 0; loadCnt = 0; loadSince = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeEntry(input int i, input logic [CHAN_W-1:0] ch,
                            input logic [GAIN_W-1:0] gn_, input logic dg);
    @(posedge clk); #1;
    listWrEn = 1'b1; listWrIdx = IDX_W'(i);
    listWrChan = ch; listWrGain = gn_; listWrDigital = dg;
    @(posedge clk); #1;
    listWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic waitDone();
    while (doneCnt == 0) @(negedge clk);
    tick(4);
  endtask

  function automatic int unsigned avgOf(input int unsigned g0, input int b, input int sh);
    longint unsigned s = 0;
    for (int j = 0; j < b; j++) s += fval(g0 + j);
    return int'(s >> sh);
  endfunction

  // stimulus / expected-result table
  typedef struct packed {
    logic       osEn;
    logic [3:0] log2v;
    logic       line;
    logic       sel60;
    logic [3:0] nEnt;
    logic [7:0] digMask;
    logic [4:0] chanBase;
    logic [7:0] expGap;
    logic       expErr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd2,  1'b0, 1'b0, 4'd4, 8'h02, 5'd3,  8'd4,   1'b0},
    '{1'b0, 4'd5,  1'b0, 1'b0, 4'd3, 8'h00, 5'd10, 8'd4,   1'b0},
    '{1'b1, 4'd0,  1'b0, 1'b0, 4'd2, 8'h00, 5'd1,  8'd4,   1'b0},
    '{1'b1, 4'd15, 1'b0, 1'b0, 4'd1, 8'h00, 5'd20, 8'd4,   1'b0},
    '{1'b1, 4'd6,  1'b1, 1'b0, 4'd2, 8'h00, 5'd5,  8'd128, 1'b0},
    '{1'b1, 4'd6,  1'b1, 1'b1, 4'd1, 8'h00, 5'd7,  8'd106, 1'b0},
    '{1'b1, 4'd12, 1'b1, 1'b0, 4'd1, 8'h00, 5'd9,  8'd2,   1'b1},
    '{1'b1, 4'd8,  1'b0, 1'b0, 4'd3, 8'h07, 5'd12, 8'd4,   1'b0}
  };

  bit finished = 0;

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unsigned g0;
    int k, b, sh, totalConv;
    bit anyBurst;
    string tag;

    clrStats();
    tick(3);
    rst = 1'b0;
    tick(1);
    // R13 reset state
    chk(busy == 1'b0,      "R13", "busy after reset", busy, 0);
    chk(outValid == 1'b0,  "R13", "outValid after reset", outValid, 0);
    chk(convStart == 1'b0, "R13", "convStart after reset", convStart, 0);
    chk(done == 1'b0 && paceErr == 1'b0, "R13", "done/paceErr after reset", {done, paceErr}, 0);

    // ---------- table walk ----------
    for (int v = 0; v < NVEC; v++) begin
      for (int e = 0; e < int'(VECS[v].nEnt); e++)
        writeEntry(e, VECS[v].chanBase + CHAN_W'(e), GAIN_W'(e), VECS[v].digMask[e]);
      listLast = IDX_W'(VECS[v].nEnt - 1);
      osEnable = VECS[v].osEn; osLog2 = VECS[v].log2v;
      lineMode = VECS[v].line; line60 = VECS[v].sel60;
      continuous = 1'b0; outReady = 1'b1;
      clrStats();
      g0 = gn;
      pulseStart();
      waitDone();

      k = 0;
      if (VECS[v].osEn)
        k = (VECS[v].log2v == 0) ? 1 : ((VECS[v].log2v > 14) ? 14 : int'(VECS[v].log2v));
      totalConv = 0;
      anyBurst = 0;
      chk(recCnt == int'(VECS[v].nEnt), "R1", $sformatf("vec%0d word count", v), recCnt, VECS[v].nEnt);
      for (int e = 0; e < int'(VECS[v].nEnt); e++) begin
        if (VECS[v].digMask[e]) begin b = 1; sh = 0; tag = "R3"; end
        else if (!VECS[v].osEn) begin b = 1; sh = 0; tag = "R4"; end
        else begin
          b = 1 << k; sh = k;
          tag = (VECS[v].log2v == 0 || VECS[v].log2v > 14) ? "R12" : "R2";
        end
        if (b > 1) anyBurst = 1;
        chk(recIdx[e] == IDX_W'(e), "R1", $sformatf("vec%0d index of word %0d", v, e), recIdx[e], e);
        chk(recData[e] == SAMPLE_W'(avgOf(g0 + totalConv, b, sh)), tag,
            $sformatf("vec%0d data of entry %0d", v, e), recData[e], avgOf(g0 + totalConv, b, sh));
        chk(loadChan[e] == VECS[v].chanBase + CHAN_W'(e), "R5",
            $sformatf("vec%0d channel of entry %0d", v, e), loadChan[e], VECS[v].chanBase + e);
        totalConv += b;
      end
      chk(convCnt == totalConv, (k > 0) ? "R2" : "R4", $sformatf("vec%0d conversions", v), convCnt, totalConv);
      chk(selChange == 0, "R5", $sformatf("vec%0d selection changes in burst", v), selChange, 0);
      chk(paceErr == VECS[v].expErr, "R8", $sformatf("vec%0d paceErr", v), paceErr, VECS[v].expErr);
      chk(gapSeen == anyBurst, VECS[v].line ? "R7" : "R6", $sformatf("vec%0d gap seen", v), gapSeen, anyBurst);
      if (gapSeen) begin
        chk(minGap == int'(VECS[v].expGap) && maxGap == int'(VECS[v].expGap),
            VECS[v].line ? "R7" : "R6", $sformatf("vec%0d start gap min", v), minGap, VECS[v].expGap);
        chk(maxGap == int'(VECS[v].expGap), VECS[v].line ? "R7" : "R6",
            $sformatf("vec%0d start gap max", v), maxGap, VECS[v].expGap);
      end
      chk(doneCnt == 1, "R10", $sformatf("vec%0d done pulses", v), doneCnt, 1);
      chk(busy == 1'b0, "R10", $sformatf("vec%0d busy after done", v), busy, 0);
    end

    // ---------- R9 backpressure at entry boundary ----------
    writeEntry(0, 5'd2, 3'd1, 1'b0);
    writeEntry(1, 5'd3, 3'd2, 1'b0);
    listLast = 3'd1; osEnable = 1'b1; osLog2 = 4'd3; lineMode = 1'b0; continuous = 1'b0;
    outReady = 1'b0;
    clrStats();
    g0 = gn;
    pulseStart();
    tick(400);
    chk(outValid == 1'b1, "R9", "stalled word valid", outValid, 1);
    chk(outIdx == 3'd0, "R9", "stalled word index", outIdx, 0);
    chk(convCnt == 8, "R9", "conversions while stalled", convCnt, 8);
    chk(busy == 1'b1, "R9", "busy while stalled", busy, 1);
    outReady = 1'b1;
    waitDone();
    chk(recCnt == 2, "R9", "words after release", recCnt, 2);
    chk(recData[0] == SAMPLE_W'(avgOf(g0, 8, 3)), "R9", "first word data", recData[0], avgOf(g0, 8, 3));
    chk(recData[1] == SAMPLE_W'(avgOf(g0 + 8, 8, 3)), "R9", "second word data", recData[1], avgOf(g0 + 8, 8, 3));

    // ---------- R11 continuous wrap ----------
    osEnable = 1'b0; continuous = 1'b1; outReady = 1'b1;
    clrStats();
    g0 = gn;
    pulseStart();
    while (recCnt < 5) @(negedge clk);
    chk(doneCnt == 0, "R11", "no done while continuous", doneCnt, 0);
    for (int j = 0; j < 5; j++)
      chk(recIdx[j] == IDX_W'(j % 2), "R11", $sformatf("wrapped index %0d", j), recIdx[j], j % 2);
    @(posedge clk); #1; continuous = 1'b0;
    waitDone();
    chk(recIdx[recCnt-1] == 3'd1, "R11", "last index before stop", recIdx[recCnt-1], 1);
    for (int j = 0; j < recCnt && j < 64; j++)
      chk(recData[j] == fval(g0 + j), "R4", $sformatf("continuous data %0d", j), recData[j], fval(g0 + j));

    // ---------- R13 reset in the middle of a scan ----------
    osEnable = 1'b1; osLog2 = 4'd10; continuous = 1'b0;
    clrStats();
    pulseStart();
    tick(100);
    chk(busy == 1'b1, "R13", "busy before mid-scan reset", busy, 1);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk(busy == 1'b0 && outValid == 1'b0, "R13", "busy/outValid after mid-scan reset", {busy, outValid}, 0);
    chk(convStart == 1'b0 && paceErr == 1'b0 && done == 1'b0, "R13", "strobes after mid-scan reset",
        {convStart, paceErr, done}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule